// File: doc/BRIEF.md
# Card Host Control and Status Register Block

This block is the register front end of a card host controller. It decodes a simple word-addressed write/read bus into two control registers and one read-only status word. Each control register answers at three addresses: one replaces the whole value, one ORs the written bits in, and one clears the written bits. Software can therefore flip single bits without a read-modify-write sequence.

The main control register holds a soft-reset bit, a clock-gate bit and a run bit. Setting run launches a transaction: the block emits a one-cycle start pulse to the transaction engine. When the engine reports completion, the block clears run itself, so software polls run to detect the end. If software clears run while a transaction is still active, the block emits a one-cycle abort pulse. Setting soft reset starts an internal reset sequence of a fixed number of cycles. During that sequence the bit reads 1, and afterwards every register holds its default value.

The status word combines sticky error flags reported by the engine with live FIFO and busy inputs, and a single summary output shows whether any error is held.

Top module: `ctl_csr_block`

## Requirements
- R1: Address bits [ADDR_W-1:4] pick a slot: 0 is the main control register, 1 is the configuration register and 2 is the status word. Only word-aligned addresses (bits [1:0] = 0) are decoded. A write at slot offset 0x0 replaces the register value. A read at any aligned offset of a slot returns that slot, and a read of an unused slot returns 0.
- R2: A write at offset 0x4 ORs the written bits into the register, and a write at offset 0x8 clears the written bits. A write at offset 0xC, or any write to the status slot, changes nothing.
- R3: After hardware reset the main control register reads 0x4000_0000, with only the clock gate set, and the configuration register reads CFG_RST.
- R4: While control bit 30 (clock gate) is 1, every register write is ignored, except that a control write whose result has bit 30 at 0 clears bit 30 and leaves every other bit unchanged.
- R5: When run (control bit 29) changes from 0 to 1, eng_start_o is high for exactly the first cycle in which run reads 1. Setting run again while it is already 1 gives no pulse.
- R6: While run is 1, a cycle with eng_done_i high clears run at the next clock edge and raises no abort.
- R7: When software clears run while it is 1 and eng_done_i is low, eng_abort_o is high for one cycle, in the same cycle run first reads 0.
- R8: A write that sets control bit 31 starts soft reset. Bit 31 then reads 1 for RST_CYCLES cycles and then reads 0. While bit 31 reads 1, all writes are ignored. After the sequence both registers hold their reset values, the error flags are clear, and a running transaction is aborted.
- R9: Status layout: bit 16 response CRC error, 15 response error, 14 response timeout, 13 data CRC error, 12 timeout, 9 FIFO overflow, 8 fifo_full_i, 5 fifo_empty_i, 4 FIFO underflow, 3 cmd_busy_i, 2 data_busy_i. Every other bit reads 0. The error event input err_evt_i maps as follows: bit 0 FIFO underflow, 1 FIFO overflow, 2 timeout, 3 data CRC, 4 response timeout, 5 response error, 6 response CRC.
- R10: Error flags are sticky. They stay set after the event ends and after the transaction completes, and they are cleared only by a new start or by soft reset. err_any_o is high whenever any error flag is set.
- R11: Status bit 0 (busy) is the OR of run, cmd_busy_i and data_busy_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we_i | input | 1 | Write strobe for the current address |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| eng_done_i | input | 1 | Transaction engine reports completion |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_abort_o | output | 1 | One-cycle abort pulse to the engine |
| err_evt_i | input | 7 | Error event strobes from engine and FIFO |
| fifo_full_i | input | 1 | Live FIFO full flag |
| fifo_empty_i | input | 1 | Live FIFO empty flag |
| cmd_busy_i | input | 1 | Command phase active |
| data_busy_i | input | 1 | Data phase active |
| ctrl_o | output | 32 | Main control register as read, bit 31 showing reset in progress |
| cfg_o | output | 32 | Configuration register value |
| err_any_o | output | 1 | Any sticky error flag set |

## Verification
The bench builds the block with ADDR_W at 8 and RST_CYCLES lowered to 3. At that length the reset window can be walked one cycle at a time, so the bench sees the exact cycle in which bit 31 drops and can attempt a write while the sequence is still running. CFG_RST keeps a distinct non-zero default, so a restored value cannot be mistaken for a cleared one. The 8-bit address leaves unused slots and the fourth alias offset reachable, which lets the bench check that writes there are ignored.

// File: rtl/ctl_csr_pkg.sv
package ctl_csr_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned NUM_SLOTS = 3;
    localparam int unsigned NUM_ERR   = 7;

    localparam int unsigned BIT_SRST  = 31;
    localparam int unsigned BIT_GATE  = 30;
    localparam int unsigned BIT_RUN   = 29;

    localparam int unsigned SLOT_CTRL = 0;
    localparam int unsigned SLOT_CFG  = 1;
    localparam int unsigned SLOT_STAT = 2;

    typedef enum logic [1:0] {
        ALIAS_WRITE = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLR   = 2'd2,
        ALIAS_NONE  = 2'd3
    } alias_op_e;

    // Packed order fixes the err_evt_i bit mapping (bit 0 = fifo_udf).
    typedef struct packed {
        logic resp_crc;
        logic resp_err;
        logic resp_to;
        logic data_crc;
        logic tmo;
        logic fifo_ovf;
        logic fifo_udf;
    } err_flags_t;

    typedef struct packed {
        logic fifo_full;
        logic fifo_empty;
        logic cmd_busy;
        logic data_busy;
    } live_flags_t;

    function automatic logic [WORD_W-1:0] alias_apply(
        input alias_op_e         op,
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wd
    );
        case (op)
            ALIAS_WRITE: return wd;
            ALIAS_SET:   return cur | wd;
            ALIAS_CLR:   return cur & ~wd;
            default:     return cur;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_status(
        input err_flags_t  e,
        input live_flags_t l,
        input logic        run
    );
        logic [WORD_W-1:0] s;
        s     = '0;
        s[16] = e.resp_crc;
        s[15] = e.resp_err;
        s[14] = e.resp_to;
        s[13] = e.data_crc;
        s[12] = e.tmo;
        s[9]  = e.fifo_ovf;
        s[8]  = l.fifo_full;
        s[5]  = l.fifo_empty;
        s[4]  = e.fifo_udf;
        s[3]  = l.cmd_busy;
        s[2]  = l.data_busy;
        s[0]  = run | l.cmd_busy | l.data_busy;
        return s;
    endfunction

endpackage

// File: rtl/ctl_alias_unit.sv
module ctl_alias_unit
    import ctl_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic [NUM_SLOTS-1:0] wr_hit_o,
    output alias_op_e            op_o
);
    localparam int unsigned SLOT_W = ADDR_W - 4;

    logic aligned;

    assign aligned = (addr_i[1:0] == 2'b00);
    assign op_o    = alias_op_e'(addr_i[3:2]);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign sel_o[g]    = aligned && (addr_i[ADDR_W-1:4] == SLOT_W'(g));
        assign wr_hit_o[g] = we_i && sel_o[g] && (op_o != ALIAS_NONE);
    end

endmodule

// File: rtl/ctl_reset_seq.sv
module ctl_reset_seq #(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic kick_i,
    output logic busy_o
);
    localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (kick_i) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(RST_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/ctl_status_merge.sv
module ctl_status_merge
    import ctl_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  err_flags_t        evt_i,
    input  live_flags_t       live_i,
    input  logic              run_i,
    output logic [WORD_W-1:0] status_o,
    output logic              err_any_o
);
    err_flags_t err_q;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= '0;
        else if (clear_i) err_q <= '0;
        else              err_q <= err_q | evt_i;
    end

    assign status_o  = pack_status(err_q, live_i, run_i);
    assign err_any_o = |err_q;

endmodule

// File: rtl/ctl_csr_block.sv
module ctl_csr_block
    import ctl_csr_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       RST_CYCLES = 4,
    parameter logic [WORD_W-1:0] CTRL_RST   = 32'h4000_0000,
    parameter logic [WORD_W-1:0] CFG_RST    = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              eng_done_i,
    output logic              eng_start_o,
    output logic              eng_abort_o,
    input  logic [6:0]        err_evt_i,
    input  logic              fifo_full_i,
    input  logic              fifo_empty_i,
    input  logic              cmd_busy_i,
    input  logic              data_busy_i,
    output logic [31:0]       ctrl_o,
    output logic [31:0]       cfg_o,
    output logic              err_any_o
);
    localparam logic [WORD_W-1:0] CTRL_DEF =
        CTRL_RST & ~((WORD_W'(1) << BIT_SRST) | (WORD_W'(1) << BIT_RUN));

    logic [NUM_SLOTS-1:0] sel, wr_hit;
    alias_op_e            op;
    logic [WORD_W-1:0]    ctrl_q, ctrl_cand, ctrl_next;
    logic [WORD_W-1:0]    cfg_q, cfg_next;
    logic [WORD_W-1:0]    status;
    logic                 gated, srst_busy, kick, run_next;
    logic                 start_d, abort_d, start_q, abort_q;
    live_flags_t          live;

    ctl_alias_unit #(.ADDR_W(ADDR_W)) u_alias (
        .we_i     (bus_we_i),
        .addr_i   (bus_addr_i),
        .sel_o    (sel),
        .wr_hit_o (wr_hit),
        .op_o     (op)
    );

    ctl_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
        .clk    (clk),
        .rst    (rst),
        .kick_i (kick),
        .busy_o (srst_busy)
    );

    assign gated     = ctrl_q[BIT_GATE];
    assign ctrl_cand = alias_apply(op, ctrl_q, bus_wdata_i);

    always_comb begin
        ctrl_next = ctrl_q;
        kick      = 1'b0;
        if (wr_hit[SLOT_CTRL] && !srst_busy) begin
            if (gated) begin
                if (!ctrl_cand[BIT_GATE]) ctrl_next[BIT_GATE] = 1'b0;
            end else begin
                ctrl_next = ctrl_cand;
                kick      = ctrl_cand[BIT_SRST];
            end
        end
        ctrl_next[BIT_SRST] = 1'b0;
        run_next = ctrl_next[BIT_RUN] & ~(eng_done_i & ctrl_q[BIT_RUN]);
        if (kick || srst_busy) begin
            ctrl_next = CTRL_DEF;
            run_next  = 1'b0;
        end
        ctrl_next[BIT_RUN] = run_next;
    end

    always_comb begin
        cfg_next = cfg_q;
        if (wr_hit[SLOT_CFG] && !gated && !srst_busy)
            cfg_next = alias_apply(op, cfg_q, bus_wdata_i);
        if (kick || srst_busy)
            cfg_next = CFG_RST;
    end

    assign start_d = run_next & ~ctrl_q[BIT_RUN];
    assign abort_d = ctrl_q[BIT_RUN] & ~run_next & ~eng_done_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_DEF;
            cfg_q   <= CFG_RST;
            start_q <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_next;
            cfg_q   <= cfg_next;
            start_q <= start_d;
            abort_q <= abort_d;
        end
    end

    assign live = '{fifo_full: fifo_full_i, fifo_empty: fifo_empty_i,
                    cmd_busy: cmd_busy_i, data_busy: data_busy_i};

    ctl_status_merge u_stat (
        .clk       (clk),
        .rst       (rst),
        .clear_i   (kick | srst_busy | start_d),
        .evt_i     (err_flags_t'(err_evt_i)),
        .live_i    (live),
        .run_i     (ctrl_q[BIT_RUN]),
        .status_o  (status),
        .err_any_o (err_any_o)
    );

    always_comb begin
        ctrl_o           = ctrl_q;
        ctrl_o[BIT_SRST] = srst_busy;
    end

    always_comb begin
        if (sel[SLOT_CTRL])      bus_rdata_o = ctrl_o;
        else if (sel[SLOT_CFG])  bus_rdata_o = cfg_q;
        else if (sel[SLOT_STAT]) bus_rdata_o = status;
        else                     bus_rdata_o = '0;
    end

    assign cfg_o       = cfg_q;
    assign eng_start_o = start_q;
    assign eng_abort_o = abort_q;

endmodule

// File: rtl/ctl_csr_chk.sv
module ctl_csr_chk #(
    parameter logic [31:0] CFG_RST = 32'h0000_FFFF
) (
    input logic        clk,
    input logic        rst,
    input logic [31:0] ctrl_o,
    input logic [31:0] cfg_o,
    input logic        eng_start_o,
    input logic        eng_abort_o,
    input logic        eng_done_i,
    input logic        err_any_o
);
    AST_GATE_FREEZES_CFG: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[30] |=> $stable(cfg_o)); // R4

    AST_START_ON_RUN_RISE: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> (ctrl_o[29] && !$past(ctrl_o[29]))); // R5

    AST_DONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        (ctrl_o[29] && eng_done_i) |=> (!ctrl_o[29] && !eng_abort_o)); // R6

    AST_ABORT_ON_SW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        eng_abort_o |-> (!ctrl_o[29] && $past(ctrl_o[29]) && !$past(eng_done_i))); // R7

    AST_SRST_HOLDS_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        ctrl_o[31] |-> ((cfg_o == CFG_RST) && !ctrl_o[29] && !err_any_o)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        $fell(err_any_o) |-> (eng_start_o || ctrl_o[31])); // R10

endmodule

bind ctl_csr_block ctl_csr_chk #(.CFG_RST(CFG_RST)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctrl_o      (ctrl_o),
    .cfg_o       (cfg_o),
    .eng_start_o (eng_start_o),
    .eng_abort_o (eng_abort_o),
    .eng_done_i  (eng_done_i),
    .err_any_o   (err_any_o)
);

// File: tb/tb_ctl_csr_block.sv
module tb_ctl_csr_block;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 8;
    localparam int          RST_CYC    = 3;
    localparam logic [31:0] CFG_DEF    = 32'h0000_FFFF;
    localparam logic [31:0] RUN        = 32'h2000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              eng_done = 1'b0;
    logic              eng_start, eng_abort;
    logic [6:0]        err_evt = '0;
    logic              fifo_full = 1'b0, fifo_empty = 1'b0;
    logic              cmd_busy = 1'b0, data_busy = 1'b0;
    logic [31:0]       ctrl, cfg;
    logic              err_any;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_csr_block #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYC), .CFG_RST(CFG_DEF)) dut (
        .clk(clk), .rst(rst), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .eng_done_i(eng_done),
        .eng_start_o(eng_start), .eng_abort_o(eng_abort), .err_evt_i(err_evt),
        .fifo_full_i(fifo_full), .fifo_empty_i(fifo_empty), .cmd_busy_i(cmd_busy),
        .data_busy_i(data_busy), .ctrl_o(ctrl), .cfg_o(cfg), .err_any_o(err_any)
    );

    // Status bit position of each err_evt_i bit, from R9.
    function automatic int err_pos(input int i);
        case (i)
            0: return 4;  1: return 9;  2: return 12; 3: return 13;
            4: return 14; 5: return 15; default: return 16;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    task automatic pulse_err(input logic [6:0] e);
        @(negedge clk); err_evt = e;
        @(negedge clk); err_evt = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        bus_read(8'h00, d); chk("R3 ctrl reset", d, 32'h4000_0000);
        bus_read(8'h10, d); chk("R3 cfg reset", d, CFG_DEF);
        bus_read(8'h30, d); chk("R1 unused slot reads 0", d, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        bus_write(8'h10, 32'h0000_0001);
        bus_read(8'h10, d); chk("R4 cfg write ignored when gated", d, CFG_DEF);
        bus_write(8'h04, 32'h0000_0020);
        bus_read(8'h00, d); chk("R4 ctrl set ignored when gated", d, 32'h4000_0000);
        bus_write(8'h00, 32'h0000_0003);
        bus_read(8'h00, d); chk("R4 gate clear changes only bit 30", d, 32'h0);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        bus_write(8'h10, 32'h1234_5678);
        bus_read(8'h10, d); chk("R1 plain write", d, 32'h1234_5678);
        bus_write(8'h14, 32'h0000_00F0);
        bus_read(8'h18, d); chk("R2 set alias", d, 32'h1234_56F8);
        bus_write(8'h18, 32'h1200_0008);
        bus_read(8'h10, d); chk("R2 clear alias", d, 32'h0034_56F0);
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h10, d); chk("R2 offset C and status writes ignored", d, 32'h0034_56F0);
        bus_write(8'h04, 32'h0000_000A);
        bus_write(8'h08, 32'h0000_0002);
        bus_read(8'h00, d); chk("R2 ctrl set then clear", d, 32'h0000_0008);
        bus_write(8'h00, 32'h0000_0000);
    endtask

    task automatic t_start_done();
        logic [31:0] d;
        bus_write(8'h04, RUN);
        chk("R5 start pulse", {31'h0, eng_start}, 32'h1);
        bus_read(8'h00, d); chk("R5 run reads 1", d, RUN);
        @(negedge clk);
        chk("R5 start one cycle", {31'h0, eng_start}, 32'h0);
        bus_write(8'h04, RUN);
        chk("R5 no pulse when already running", {31'h0, eng_start}, 32'h0);
        pulse_done();
        bus_read(8'h00, d); chk("R6 done clears run", d, 32'h0);
        chk("R6 no abort on done", {31'h0, eng_abort}, 32'h0);
    endtask

    task automatic t_abort();
        logic [31:0] d;
        bus_write(8'h04, RUN);
        bus_write(8'h08, RUN);
        chk("R7 abort pulse", {31'h0, eng_abort}, 32'h1);
        bus_read(8'h00, d); chk("R7 run cleared", d, 32'h0);
        @(negedge clk);
        chk("R7 abort one cycle", {31'h0, eng_abort}, 32'h0);
    endtask

    task automatic t_status_map();
        logic [31:0] d;
        for (int i = 0; i < 7; i++) begin
            bus_write(8'h04, RUN);
            pulse_err(7'(1 << i));
            bus_read(8'h24, d);
            chk($sformatf("R9 err_evt bit %0d position", i), d, (32'h1 << err_pos(i)) | 32'h1);
            bus_write(8'h08, RUN);
        end
        fifo_full = 1'b1; cmd_busy = 1'b1;
        bus_read(8'h20, d); chk("R11 R9 full and cmd busy", d & 32'h0000_033F, 32'h0000_0109);
        fifo_full = 1'b0; cmd_busy = 1'b0; fifo_empty = 1'b1; data_busy = 1'b1;
        bus_read(8'h20, d); chk("R11 R9 empty and data busy", d & 32'h0000_033F, 32'h0000_0025);
        fifo_empty = 1'b0; data_busy = 1'b0;
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        bus_write(8'h04, RUN);
        pulse_err(7'b000_0100);
        pulse_done();
        bus_read(8'h20, d); chk("R10 error held after done", d, 32'h0000_1000);
        chk("R10 err_any high", {31'h0, err_any}, 32'h1);
        bus_write(8'h04, RUN);
        bus_read(8'h20, d); chk("R10 new start clears errors", d, 32'h0000_0001);
        chk("R10 err_any low after start", {31'h0, err_any}, 32'h0);
        pulse_done();
    endtask

    task automatic t_soft_reset();
        logic [31:0] d;
        bus_write(8'h10, 32'hAAAA_5555);
        bus_write(8'h04, RUN | 32'h0000_0100);
        pulse_err(7'b100_0000);
        bus_write(8'h04, 32'h8000_0000);
        chk("R8 running transaction aborted", {31'h0, eng_abort}, 32'h1);
        bus_read(8'h00, d); chk("R8 bit 31 reads 1 cycle 0", d, 32'hC000_0000);
        for (int k = 1; k < RST_CYC; k++) begin
            @(negedge clk);
            bus_read(8'h00, d);
            chk($sformatf("R8 bit 31 reads 1 cycle %0d", k), d, 32'hC000_0000);
        end
        @(negedge clk);
        bus_read(8'h00, d); chk("R8 ctrl default after reset", d, 32'h4000_0000);
        bus_read(8'h10, d); chk("R8 cfg default after reset", d, CFG_DEF);
        chk("R8 errors cleared", {31'h0, err_any}, 32'h0);
        bus_write(8'h08, 32'h4000_0000);
        bus_write(8'h04, 32'h8000_0000);
        bus_write(8'h10, 32'h0000_0001);
        for (int k = 0; k < RST_CYC; k++) @(negedge clk);
        bus_read(8'h10, d); chk("R8 write during reset ignored", d, CFG_DEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_gate();
        t_alias();
        t_start_done();
        t_abort();
        t_status_map();
        t_sticky();
        t_soft_reset();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule